// File: doc/BRIEF.md
# Programmable Reference Divider with Polarity-Selectable Phase-Frequency Detector

This block turns a stream of reference clock enables into a comparison tick by dividing it by a programmable ratio R. It then compares that tick with a divided feedback tick from the oscillator path in a three-state phase-frequency detector. The detector produces two pump requests: one that raises the control voltage and one that lowers it. A polarity bit swaps the two requests, so the same loop can steer an oscillator whose frequency rises or falls with its tuning voltage. For example, a 4 MHz reference with R = 64 gives a 62.5 kHz comparison rate, and R = 16 gives 250 kHz.

Configuration arrives as a complete 24-bit word, one `cfg_valid` pulse per word. Each instance answers one select code, given by a parameter. The default code 00 suits the second loop; code 10 suits the first. A word carrying a ratio below 3 is refused, and an error flag is raised.

The detector is a state machine with four states. `DET_IDLE` has no request pending. `DET_REF_AHEAD` drives the raise request. `DET_FB_AHEAD` drives the lower request. `DET_CLEAR` drives both requests for exactly one cycle.

Its transitions are:
- A comparison tick alone takes IDLE to REF_AHEAD.
- A feedback tick alone takes IDLE to FB_AHEAD.
- Both ticks together take IDLE to CLEAR.
- A feedback tick takes REF_AHEAD to CLEAR.
- A comparison tick takes FB_AHEAD to CLEAR.
- CLEAR always returns to IDLE.
- A repeated tick from the side that is already ahead leaves the state unchanged.

Top module: `refdiv_pfd`

## Requirements
- R1: After reset the ratio is 64, polarity is 0, the error flag is 0, and `cmp_tick`, `pump_up` and `pump_dn` are all low.
- R2: A word is taken only when `cfg_valid` is high and bits 1:0 equal the instance's select code (default 00). A word with any other code, or no `cfg_valid`, leaves the ratio and polarity unchanged.
- R3: Field layout of the 24-bit word: R at bits 16:2 (bit 2 is the LSB), polarity at bit 17. Bits 21:18 and 23:22 have no effect.
- R4: A matching word whose R is 0, 1 or 2 leaves both ratio and polarity unchanged and sets `cfg_err` in the next cycle. A matching word with R of 3 or more clears `cfg_err`. The ratio is never below 3.
- R5: `cmp_tick` is a one-cycle pulse. It rises the cycle after every R-th `ref_tick`.
- R6: An accepted word restarts the division. With `ref_tick` high every cycle, the first `cmp_tick` comes R cycles after the capturing edge, and later ones come every R cycles, for R from 3 to 32767.
- R7: One cycle after a `cmp_tick` with no request pending, the raise request is driven and held until feedback arrives. A `fb_tick` with no request pending drives the lower request in the same way. The requests change only in the cycle after a tick, or when leaving the clear state.
- R8: When both sides have arrived, both requests are high for one cycle and then both go low. This includes a comparison tick and a feedback tick in the same cycle.
- R9: With polarity 1, `pump_up` and `pump_dn` carry each other's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration word strobe |
| cfg_word | input | 24 | Configuration word |
| ref_tick | input | 1 | Reference clock enable, one per reference period |
| fb_tick | input | 1 | Divided feedback pulse |
| cmp_tick | output | 1 | Divided reference pulse |
| pump_up | output | 1 | Raise request after polarity swap |
| pump_dn | output | 1 | Lower request after polarity swap |
| r_ratio | output | 15 | Current division ratio |
| pol_inv | output | 1 | Current polarity bit |
| cfg_err | output | 1 | Last matching word was refused |

## Verification
The assertions check these properties on every cycle:
- the ratio never falls below 3;
- the configuration holds steady without a strobe, and the error flag rises only after a strobe;
- the comparison tick never lasts two cycles;
- the clear state lasts exactly one cycle;
- a request only rises in the cycle after a tick.

Only the bench scenarios can show:
- the exact divider latency and period across a sweep of ratios, including both range limits;
- that wrong select codes and reserved bits really leave the state alone;
- the request order for reference-first, feedback-first and simultaneous arrival, with both polarities.

// File: rtl/refdiv_pfd_pkg.sv
package refdiv_pfd_pkg;
    localparam int SEL_W     = 2;
    localparam int MIN_RATIO = 3;

    typedef enum logic [1:0] {
        DET_IDLE      = 2'd0,
        DET_REF_AHEAD = 2'd1,
        DET_FB_AHEAD  = 2'd2,
        DET_CLEAR     = 2'd3
    } det_state_t;
endpackage

// File: rtl/refdiv_pfd_cfg.sv
module refdiv_pfd_cfg
    import refdiv_pfd_pkg::*;
#(
    parameter int         RW       = 15,
    parameter int         WORD_W   = 24,
    parameter logic [1:0] SEL_CODE = 2'b00,
    parameter int         RESET_R  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [WORD_W-1:0] cfg_word,
    output logic [RW-1:0]     ratio,
    output logic              invert,
    output logic              err,
    output logic              restart
);
    localparam int R_LSB   = SEL_W;
    localparam int R_MSB   = R_LSB + RW - 1;
    localparam int POL_BIT = R_MSB + 1;

    logic [RW-1:0] cand;
    logic          hit;
    logic          legal;

    assign cand    = cfg_word[R_MSB:R_LSB];
    assign hit     = cfg_valid && (cfg_word[SEL_W-1:0] == SEL_CODE);
    assign legal   = (cand >= RW'(MIN_RATIO));
    assign restart = hit && legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio  <= RW'(RESET_R);
            invert <= 1'b0;
            err    <= 1'b0;
        end else if (hit) begin
            if (legal) begin
                ratio  <= cand;
                invert <= cfg_word[POL_BIT];
                err    <= 1'b0;
            end else begin
                err    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/refdiv_pfd_cnt.sv
module refdiv_pfd_cnt #(
    parameter int RW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          ref_tick,
    input  logic [RW-1:0] ratio,
    output logic          tick_out
);
    logic [RW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt >= ratio - RW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            tick_out <= 1'b0;
        end else if (restart) begin
            cnt      <= '0;
            tick_out <= 1'b0;
        end else if (ref_tick) begin
            cnt      <= wrap ? '0 : cnt + RW'(1);
            tick_out <= wrap;
        end else begin
            tick_out <= 1'b0;
        end
    end
endmodule

// File: rtl/refdiv_pfd_det.sv
module refdiv_pfd_det
    import refdiv_pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ev,
    input  logic fb_ev,
    input  logic invert,
    output logic up,
    output logic dn
);
    det_state_t state, state_nx;
    logic       raise_req, lower_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DET_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DET_IDLE: begin
                if (ref_ev && fb_ev) state_nx = DET_CLEAR;
                else if (ref_ev)     state_nx = DET_REF_AHEAD;
                else if (fb_ev)      state_nx = DET_FB_AHEAD;
            end
            DET_REF_AHEAD: if (fb_ev)  state_nx = DET_CLEAR;
            DET_FB_AHEAD:  if (ref_ev) state_nx = DET_CLEAR;
            DET_CLEAR:     state_nx = DET_IDLE;
            default:       state_nx = DET_IDLE;
        endcase
    end

    always_comb begin
        raise_req = 1'b0;
        lower_req = 1'b0;
        unique case (state)
            DET_IDLE:      ;
            DET_REF_AHEAD: raise_req = 1'b1;
            DET_FB_AHEAD:  lower_req = 1'b1;
            DET_CLEAR: begin
                raise_req = 1'b1;
                lower_req = 1'b1;
            end
            default:       ;
        endcase
        up = invert ? lower_req : raise_req;
        dn = invert ? raise_req : lower_req;
    end
endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd #(
    parameter int         RW       = 15,
    parameter int         WORD_W   = 24,
    parameter logic [1:0] SEL_CODE = 2'b00,
    parameter int         RESET_R  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              ref_tick,
    input  logic              fb_tick,
    output logic              cmp_tick,
    output logic              pump_up,
    output logic              pump_dn,
    output logic [RW-1:0]     r_ratio,
    output logic              pol_inv,
    output logic              cfg_err
);
    logic restart;

    refdiv_pfd_cfg #(
        .RW(RW), .WORD_W(WORD_W), .SEL_CODE(SEL_CODE), .RESET_R(RESET_R)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
        .ratio(r_ratio), .invert(pol_inv), .err(cfg_err), .restart(restart)
    );

    refdiv_pfd_cnt #(.RW(RW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .ref_tick(ref_tick),
        .ratio(r_ratio), .tick_out(cmp_tick)
    );

    refdiv_pfd_det det_i (
        .clk(clk), .rst_n(rst_n), .ref_ev(cmp_tick), .fb_ev(fb_tick),
        .invert(pol_inv), .up(pump_up), .dn(pump_dn)
    );
endmodule

// File: rtl/refdiv_pfd_chk.sv
module refdiv_pfd_chk #(
    parameter int RW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_valid,
    input logic          fb_tick,
    input logic          cmp_tick,
    input logic          pump_up,
    input logic          pump_dn,
    input logic [RW-1:0] r_ratio,
    input logic          pol_inv,
    input logic          cfg_err
);
    assert_ratio_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_ratio >= RW'(3));

    assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(cfg_valid));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> ($stable(r_ratio) && $stable(pol_inv)));

    assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_tick |=> !cmp_tick);

    assert_clear_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && pump_dn) |=> (!pump_up && !pump_dn));

    assert_req_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pump_up) || $rose(pump_dn)) |-> $past(cmp_tick || fb_tick));
endmodule

bind refdiv_pfd refdiv_pfd_chk #(.RW(RW)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .fb_tick(fb_tick),
    .cmp_tick(cmp_tick), .pump_up(pump_up), .pump_dn(pump_dn),
    .r_ratio(r_ratio), .pol_inv(pol_inv), .cfg_err(cfg_err)
);

// File: tb/refdiv_pfd_tb_top.sv
`timescale 1ns/1ps
module refdiv_pfd_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [23:0] cfg_word = '0;
    logic        ref_tick = 1'b0;
    logic        fb_tick = 1'b0;
    logic        cmp_tick, pump_up, pump_dn, pol_inv, cfg_err;
    logic [14:0] r_ratio;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    refdiv_pfd dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
        .ref_tick(ref_tick), .fb_tick(fb_tick), .cmp_tick(cmp_tick),
        .pump_up(pump_up), .pump_dn(pump_dn), .r_ratio(r_ratio),
        .pol_inv(pol_inv), .cfg_err(cfg_err)
    );

    function automatic logic [23:0] mk(input logic [1:0] sel, input int r,
                                       input logic pol, input logic junk);
        logic [23:0] w;
        w        = '0;
        w[1:0]   = sel;
        w[16:2]  = r[14:0];
        w[17]    = pol;
        w[21:18] = {4{junk}};
        w[23:22] = {2{junk}};
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write(input logic [23:0] w);
        cfg_word  = w;
        cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic wait_tick(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cmp_tick && n < limit);
    endtask

    task automatic ref_burst();
        ref_tick = 1'b1;
        repeat (3) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic pulse_fb();
        fb_tick = 1'b1;
        @(negedge clk);
        fb_tick = 1'b0;
    endtask

    task automatic lead_case(input bit ref_first, input bit inv);
        int ea, eb;
        write(mk(2'b00, 3, inv, 1'b0));
        if (ref_first) begin
            ref_burst();
            chk(cmp_tick == 1'b1, "R5 cmp_tick after 3 ticks", cmp_tick, 1);
        end else begin
            pulse_fb();
        end
        if (ref_first) @(negedge clk);
        ea = (ref_first ^ inv) ? 1 : 0;
        eb = 1 - ea;
        chk(pump_up == ea[0] && pump_dn == eb[0], inv ? "R9 swapped lead" : "R7 lead",
            {pump_up, pump_dn}, {ea[0], eb[0]});
        repeat (3) @(negedge clk);
        chk(pump_up == ea[0] && pump_dn == eb[0], "R7 request held",
            {pump_up, pump_dn}, {ea[0], eb[0]});
        if (ref_first) pulse_fb();
        else begin
            ref_burst();
            @(negedge clk);
        end
        chk(pump_up && pump_dn, "R8 both set", {pump_up, pump_dn}, 3);
        @(negedge clk);
        chk(!pump_up && !pump_dn, "R8 both cleared", {pump_up, pump_dn}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        do_reset();
        // R1 reset state
        chk(r_ratio == 15'd64, "R1 ratio", r_ratio, 64);
        chk(!pol_inv && !cfg_err, "R1 pol/err", {pol_inv, cfg_err}, 0);
        chk(!pump_up && !pump_dn && !cmp_tick, "R1 outputs",
            {cmp_tick, pump_up, pump_dn}, 0);

        // R2 select decoding
        for (int s = 1; s < 4; s++) begin
            write(mk(s[1:0], 100, 1'b1, 1'b0));
            chk(r_ratio == 15'd64 && !pol_inv, "R2 foreign code ignored", r_ratio, 64);
        end
        cfg_word = mk(2'b00, 100, 1'b1, 1'b0);
        @(negedge clk);
        chk(r_ratio == 15'd64, "R2 no strobe ignored", r_ratio, 64);
        write(mk(2'b00, 100, 1'b0, 1'b0));
        chk(r_ratio == 15'd100, "R2 own code taken", r_ratio, 100);

        // R3 field layout, reserved bits
        write(mk(2'b00, 5, 1'b0, 1'b1));
        chk(r_ratio == 15'd5 && !pol_inv, "R3 reserved bits no effect", {pol_inv, r_ratio}, 5);
        write(mk(2'b00, 21845, 1'b1, 1'b0));
        chk(r_ratio == 15'd21845 && pol_inv, "R3 ratio and polarity bit",
            {pol_inv, r_ratio}, 32768 + 21845);

        // R4 illegal ratios
        for (int r = 0; r < 3; r++) begin
            write(mk(2'b00, r, 1'b0, 1'b0));
            chk(cfg_err && r_ratio == 15'd21845 && pol_inv, "R4 illegal ratio refused",
                {cfg_err, r_ratio}, 32768 + 21845);
        end
        write(mk(2'b00, 3, 1'b0, 1'b0));
        chk(!cfg_err && r_ratio == 15'd3, "R4 minimum accepted, err cleared",
            {cfg_err, r_ratio}, 3);

        // R5/R6 divider sweep with continuous reference
        ref_tick = 1'b1;
        for (int r = 3; r <= 40; r++) begin
            write(mk(2'b00, r, 1'b0, 1'b0));
            wait_tick(r + 5, n);
            chk(n == r, "R6 first tick latency", n, r);
            wait_tick(r + 5, n);
            chk(n == r, "R5 tick period", n, r);
        end
        write(mk(2'b00, 32767, 1'b0, 1'b0));
        wait_tick(32800, n);
        chk(n == 32767, "R6 maximum ratio latency", n, 32767);
        ref_tick = 1'b0;

        // R7/R8/R9 detector ordering
        do_reset();
        lead_case(1'b1, 1'b0);
        do_reset();
        lead_case(1'b0, 1'b0);
        do_reset();
        lead_case(1'b1, 1'b1);
        do_reset();
        lead_case(1'b0, 1'b1);

        // R8 simultaneous arrival
        do_reset();
        write(mk(2'b00, 3, 1'b0, 1'b0));
        ref_burst();
        fb_tick = 1'b1;
        @(negedge clk);
        fb_tick = 1'b0;
        chk(pump_up && pump_dn, "R8 simultaneous both set", {pump_up, pump_dn}, 3);
        @(negedge clk);
        chk(!pump_up && !pump_dn, "R8 simultaneous cleared", {pump_up, pump_dn}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule